// File: doc/BRIEF.md
# 1-of-16 PPM Command Decoder

This block recovers interrogator commands from a demodulated gap signal. A command symbol starts with a reference gap. After it come sixteen equal time positions. A second gap placed in one of those positions carries a 4-bit value, and that value is the index of the position. All timing is measured by counting cycles of the sampling clock from the leading edge of the reference gap. Two timing profiles are supported, a slow one and a fast one, and a mode input picks between them for each symbol.

Each symbol is checked for gap count and gap width, then reported with a one-cycle strobe or an error strobe. Three good symbols in a row make one 12-bit matching-code word. For each word the block reports the 8 identifier bits, the 3-bit code type and the result of an even-parity check.

Top module: `ppm_cmd_decoder`

## Requirements
- R1: After reset every strobe output is low and sym_data_o, mc_id_o and mc_type_o are zero.
- R2: Let P be the position width in cycles. The reference gap's rising edge, seen at a clock edge, is cycle 0. Cycles 0..P-1 form the reference position. A data gap whose rising edge falls in cycles P*(v+1)..P*(v+2)-1 decodes to value v, for v = 0..15.
- R3: The slow profile (fast_mode_i=0) uses P=35 cycles, and a gap is accepted if it stays high for 4 to 30 cycles inclusive.
- R4: The fast profile (fast_mode_i=1) uses P=10 cycles, and a gap is accepted if it stays high for 6 to 8 cycles inclusive.
- R5: fast_mode_i is sampled only at the reference gap's rising edge. Changing it later in the symbol does not change the result.
- R6: A data gap or a reference gap whose width is outside the profile's window gives sym_err_o and no sym_valid_o for that symbol.
- R7: A symbol with no data gap, or with more than one gap after the reference gap, gives sym_err_o and no sym_valid_o.
- R8: Exactly one of sym_valid_o and sym_err_o pulses for one cycle per symbol. The pulse comes one cycle after the first cycle that is at least 17*P cycles past cycle 0 and has the gap low. For a well-formed symbol that is cycle 17*P+1.
- R9: Three consecutive good symbols form a word. The first symbol is mc_id_o[7:4]. The second is mc_id_o[3:0]. The third carries the code type in bits [3:1] and the parity bit in bit 0.
- R10: If the 12 word bits hold an even number of ones, mc_valid_o pulses. Otherwise parity_err_o pulses. Either pulse comes in the same cycle as the third symbol's sym_valid_o.
- R11: A symbol error discards a partly collected word, and the next good symbol becomes the first of a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| gap_i | input | 1 | Demodulated gap, 1 while the carrier is gapped |
| fast_mode_i | input | 1 | Profile select: 0 slow, 1 fast |
| sym_valid_o | output | 1 | One-cycle strobe for a good symbol |
| sym_err_o | output | 1 | One-cycle strobe for a rejected symbol |
| sym_data_o | output | 4 | Value of the last good symbol |
| mc_valid_o | output | 1 | Word complete, parity correct |
| parity_err_o | output | 1 | Word complete, parity wrong |
| mc_id_o | output | 8 | Identifier bits of the last word |
| mc_type_o | output | 3 | Code type of the last word |

## Verification
The strobe for the third symbol and the word verdict are registered at the same clock edge, so the two functions fall in one cycle. The bench provokes this by sending words with correct and with wrong parity. It records the cycle index of both pulses and requires them to match, and it checks that the parity bit seen on sym_data_o agrees with the reported identifier and type. It also places a rejected symbol in the middle of a word, to show that the next word is collected from scratch and is not mixed with older symbols.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
    localparam int POSITIONS = 16;
    localparam int SYM_W     = 4;
    localparam int ID_W      = 8;
    localparam int TYPE_W    = 3;

    typedef enum logic { ST_IDLE = 1'b0, ST_FRAME = 1'b1 } dec_state_e;

    typedef struct packed {
        dec_state_e       st;
        logic             fast;
        logic             err;
        logic [1:0]       ngap;
        logic [SYM_W-1:0] val;
        logic             sym_valid;
        logic             sym_err;
        logic [SYM_W-1:0] sym_data;
    } dec_reg_t;

    typedef struct packed {
        logic [1:0]        idx;
        logic [SYM_W-1:0]  hi;
        logic [SYM_W-1:0]  mid;
        logic              mc;
        logic              perr;
        logic [ID_W-1:0]   id;
        logic [TYPE_W-1:0] typ;
    } word_reg_t;
endpackage

// File: rtl/ppm_gap_meter.sv
module ppm_gap_meter #(
    parameter int WCNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gap_i,
    input  logic [WCNT_W-1:0] min_i,
    input  logic [WCNT_W-1:0] max_i,
    output logic              rise_o,
    output logic              fall_o,
    output logic              width_ok_o
);
    typedef struct packed {
        logic              gap;
        logic [WCNT_W-1:0] wcnt;
    } meter_t;

    meter_t q, d;

    assign rise_o     = gap_i & ~q.gap;
    assign fall_o     = ~gap_i & q.gap;
    assign width_ok_o = (q.wcnt >= min_i) && (q.wcnt <= max_i);

    always_comb begin
        d     = q;
        d.gap = gap_i;
        if (rise_o) begin
            d.wcnt = WCNT_W'(1);
        end else if (gap_i && (q.wcnt != {WCNT_W{1'b1}})) begin
            d.wcnt = q.wcnt + WCNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ppm_slot_timer.sv
module ppm_slot_timer #(
    parameter int SUB_W     = 6,
    parameter int SLOT_W    = 5,
    parameter int LAST_SLOT = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              run_i,
    input  logic [SUB_W-1:0]  pos_cyc_i,
    output logic [SLOT_W-1:0] slot_o
);
    typedef struct packed {
        logic [SUB_W-1:0]  sub;
        logic [SLOT_W-1:0] slot;
    } timer_t;

    timer_t q, d;

    assign slot_o = q.slot;

    always_comb begin
        d = q;
        if (start_i) begin
            d.sub  = SUB_W'(1);
            d.slot = '0;
        end else if (run_i) begin
            if (q.sub == (pos_cyc_i - SUB_W'(1))) begin
                d.sub = '0;
                if (q.slot != SLOT_W'(LAST_SLOT)) d.slot = q.slot + SLOT_W'(1);
            end else begin
                d.sub = q.sub + SUB_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ppm_word_asm.sv
module ppm_word_asm
    import ppm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              good_i,
    input  logic              bad_i,
    input  logic [SYM_W-1:0]  nib_i,
    output logic              mc_valid_o,
    output logic              parity_err_o,
    output logic [ID_W-1:0]   id_o,
    output logic [TYPE_W-1:0] type_o
);
    word_reg_t q, d;

    assign mc_valid_o   = q.mc;
    assign parity_err_o = q.perr;
    assign id_o         = q.id;
    assign type_o       = q.typ;

    always_comb begin
        d      = q;
        d.mc   = 1'b0;
        d.perr = 1'b0;
        if (bad_i) begin
            d.idx = 2'd0;
        end else if (good_i) begin
            unique case (q.idx)
                2'd0: begin d.hi  = nib_i; d.idx = 2'd1; end
                2'd1: begin d.mid = nib_i; d.idx = 2'd2; end
                default: begin
                    d.idx = 2'd0;
                    d.id  = {q.hi, q.mid};
                    d.typ = nib_i[SYM_W-1:1];
                    if (^{q.hi, q.mid, nib_i} == 1'b0) d.mc   = 1'b1;
                    else                               d.perr = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ppm_cmd_decoder.sv
module ppm_cmd_decoder
    import ppm_pkg::*;
#(
    parameter int NORM_POS_CYC = 35,
    parameter int FAST_POS_CYC = 10,
    parameter int NORM_GAP_MIN = 4,
    parameter int NORM_GAP_MAX = 30,
    parameter int FAST_GAP_MIN = 6,
    parameter int FAST_GAP_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gap_i,
    input  logic              fast_mode_i,
    output logic              sym_valid_o,
    output logic              sym_err_o,
    output logic [SYM_W-1:0]  sym_data_o,
    output logic              mc_valid_o,
    output logic              parity_err_o,
    output logic [ID_W-1:0]   mc_id_o,
    output logic [TYPE_W-1:0] mc_type_o
);
    localparam int MAX_POS   = (NORM_POS_CYC > FAST_POS_CYC) ? NORM_POS_CYC : FAST_POS_CYC;
    localparam int MAX_GAP   = (NORM_GAP_MAX > FAST_GAP_MAX) ? NORM_GAP_MAX : FAST_GAP_MAX;
    localparam int SUB_W     = $clog2(MAX_POS + 1);
    localparam int WCNT_W    = $clog2(MAX_GAP + 2) + 1;
    localparam int LAST_SLOT = POSITIONS + 1;
    localparam int SLOT_W    = $clog2(LAST_SLOT + 1);

    localparam logic [SUB_W-1:0]  NPOS = SUB_W'(NORM_POS_CYC);
    localparam logic [SUB_W-1:0]  FPOS = SUB_W'(FAST_POS_CYC);
    localparam logic [WCNT_W-1:0] NMIN = WCNT_W'(NORM_GAP_MIN);
    localparam logic [WCNT_W-1:0] NMAX = WCNT_W'(NORM_GAP_MAX);
    localparam logic [WCNT_W-1:0] FMIN = WCNT_W'(FAST_GAP_MIN);
    localparam logic [WCNT_W-1:0] FMAX = WCNT_W'(FAST_GAP_MAX);

    dec_reg_t q, d;

    logic              rise, fall, width_ok;
    logic [SLOT_W-1:0] slot;
    logic [SUB_W-1:0]  pos_cyc;
    logic [WCNT_W-1:0] gmin, gmax;
    logic              start, run, finish, err_now;

    assign pos_cyc = q.fast ? FPOS : NPOS;
    assign gmin    = q.fast ? FMIN : NMIN;
    assign gmax    = q.fast ? FMAX : NMAX;
    assign start   = (q.st == ST_IDLE) && rise;
    assign run     = (q.st == ST_FRAME);
    assign finish  = run && (slot == SLOT_W'(LAST_SLOT)) && !gap_i;

    ppm_gap_meter #(.WCNT_W(WCNT_W)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .gap_i      (gap_i),
        .min_i      (gmin),
        .max_i      (gmax),
        .rise_o     (rise),
        .fall_o     (fall),
        .width_ok_o (width_ok)
    );

    ppm_slot_timer #(.SUB_W(SUB_W), .SLOT_W(SLOT_W), .LAST_SLOT(LAST_SLOT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .run_i     (run),
        .pos_cyc_i (pos_cyc),
        .slot_o    (slot)
    );

    always_comb begin
        d           = q;
        d.sym_valid = 1'b0;
        d.sym_err   = 1'b0;
        err_now     = q.err;
        unique case (q.st)
            ST_IDLE: begin
                if (rise) begin
                    d.st   = ST_FRAME;
                    d.fast = fast_mode_i;
                    d.err  = 1'b0;
                    d.ngap = 2'd0;
                end
            end
            default: begin
                if (fall && !width_ok) err_now = 1'b1;
                if (rise) begin
                    if ((slot == '0) || (slot == SLOT_W'(LAST_SLOT))) begin
                        err_now = 1'b1;
                    end else begin
                        if (q.ngap != 2'd2) d.ngap = q.ngap + 2'd1;
                        d.val = SYM_W'(slot - SLOT_W'(1));
                    end
                end
                d.err = err_now;
                if (finish) begin
                    d.st = ST_IDLE;
                    if (!err_now && (d.ngap == 2'd1)) begin
                        d.sym_valid = 1'b1;
                        d.sym_data  = d.val;
                    end else begin
                        d.sym_err = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    ppm_word_asm u_word (
        .clk          (clk),
        .rst_n        (rst_n),
        .good_i       (d.sym_valid),
        .bad_i        (d.sym_err),
        .nib_i        (d.sym_data),
        .mc_valid_o   (mc_valid_o),
        .parity_err_o (parity_err_o),
        .id_o         (mc_id_o),
        .type_o       (mc_type_o)
    );

    assign sym_valid_o = q.sym_valid;
    assign sym_err_o   = q.sym_err;
    assign sym_data_o  = q.sym_data;
endmodule

// File: rtl/ppm_cmd_decoder_chk.sv
module ppm_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sym_valid_o,
    input logic       sym_err_o,
    input logic [3:0] sym_data_o,
    input logic       mc_valid_o,
    input logic       parity_err_o,
    input logic [7:0] mc_id_o,
    input logic [2:0] mc_type_o
);
    p_verdict_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sym_valid_o && sym_err_o));

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid_o || sym_err_o) |=> !(sym_valid_o || sym_err_o));

    p_word_with_sym_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_valid_o || parity_err_o) |-> sym_valid_o);

    p_word_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mc_valid_o && parity_err_o));

    p_parity_even_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mc_valid_o |-> (^{mc_id_o, mc_type_o, sym_data_o[0]} == 1'b0));

    p_type_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_valid_o || parity_err_o) |-> (mc_type_o == sym_data_o[3:1]));
endmodule

bind ppm_cmd_decoder ppm_cmd_decoder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sym_valid_o  (sym_valid_o),
    .sym_err_o    (sym_err_o),
    .sym_data_o   (sym_data_o),
    .mc_valid_o   (mc_valid_o),
    .parity_err_o (parity_err_o),
    .mc_id_o      (mc_id_o),
    .mc_type_o    (mc_type_o)
);

// File: tb/tb_ppm_cmd_decoder.sv
`timescale 1ns/1ps
module tb_ppm_cmd_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gap_i = 1'b0;
    logic       fast_mode_i = 1'b0;
    logic       sym_valid_o, sym_err_o, mc_valid_o, parity_err_o;
    logic [3:0] sym_data_o;
    logic [7:0] mc_id_o;
    logic [2:0] mc_type_o;

    int checks = 0;
    int failures = 0;

    int n_sv, n_se, n_mc, n_pe, sv_idx, word_idx;
    logic [3:0] cap_data;
    logic [7:0] cap_id;
    logic [2:0] cap_type;

    always #2 clk = ~clk;

    ppm_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .gap_i(gap_i), .fast_mode_i(fast_mode_i),
        .sym_valid_o(sym_valid_o), .sym_err_o(sym_err_o), .sym_data_o(sym_data_o),
        .mc_valid_o(mc_valid_o), .parity_err_o(parity_err_o),
        .mc_id_o(mc_id_o), .mc_type_o(mc_type_o)
    );

    // fields: [15] fast, [14] expect error, [13:9] data gap width, [8:5] value
    localparam logic [15:0] VEC [10] = '{
        {1'b0, 1'b0, 5'd20, 4'd0,  5'd0},  // R2 R3 nominal
        {1'b0, 1'b0, 5'd30, 4'd7,  5'd0},  // R3 widest
        {1'b0, 1'b0, 5'd4,  4'd15, 5'd0},  // R3 narrowest, last position
        {1'b0, 1'b1, 5'd3,  4'd9,  5'd0},  // R6 too short
        {1'b0, 1'b1, 5'd31, 4'd2,  5'd0},  // R6 too long
        {1'b1, 1'b0, 5'd7,  4'd3,  5'd0},  // R4 nominal
        {1'b1, 1'b0, 5'd6,  4'd12, 5'd0},  // R4 narrowest
        {1'b1, 1'b0, 5'd8,  4'd15, 5'd0},  // R4 widest
        {1'b1, 1'b1, 5'd9,  4'd5,  5'd0},  // R6 fast too long
        {1'b1, 1'b1, 5'd5,  4'd0,  5'd0}   // R6 fast too short
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // v1/v2 < 0 means no gap; flip toggles fast_mode_i partway through
    task automatic send_frame(input bit fast, input bit flip, input int refw,
                              input int v1, input int w1, input int v2, input int w2);
        int p;
        int len;
        p = fast ? 10 : 35;
        len = 18 * p + 6;
        n_sv = 0; n_se = 0; n_mc = 0; n_pe = 0; sv_idx = -1; word_idx = -2;
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            if (sym_valid_o) begin n_sv++; cap_data = sym_data_o; sv_idx = c; end
            if (sym_err_o) n_se++;
            if (mc_valid_o || parity_err_o) begin
                word_idx = c; cap_id = mc_id_o; cap_type = mc_type_o;
                if (mc_valid_o) n_mc++;
                if (parity_err_o) n_pe++;
            end
            fast_mode_i = (flip && c >= 3) ? ~fast : fast;
            gap_i = (c < refw)
                 || (v1 >= 0 && c >= p*(v1+1) && c < p*(v1+1)+w1)
                 || (v2 >= 0 && c >= p*(v2+1) && c < p*(v2+1)+w2);
        end
        fast_mode_i = 1'b0;
    endtask

    task automatic good_sym(input bit fast, input int v, input string tag);
        send_frame(fast, 1'b0, fast ? 7 : 20, v, fast ? 7 : 20, -1, 0);
        chk(n_sv == 1 && n_se == 0 && cap_data == 4'(v), tag, int'(cap_data), v);
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!sym_valid_o && !sym_err_o && !mc_valid_o && !parity_err_o, "R1 strobes", 1, 0);
        chk(sym_data_o == 0 && mc_id_o == 0 && mc_type_o == 0, "R1 data", int'(mc_id_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < 10; i++) begin
            send_frame(VEC[i][15], 1'b0, VEC[i][15] ? 7 : 20,
                       int'(VEC[i][8:5]), int'(VEC[i][13:9]), -1, 0);
            if (VEC[i][14])
                chk(n_se == 1 && n_sv == 0, $sformatf("R6 vec%0d reject", i), n_sv, 0);
            else
                chk(n_sv == 1 && n_se == 0 && cap_data == VEC[i][8:5],
                    $sformatf("R2 R3 R4 vec%0d value", i), int'(cap_data), int'(VEC[i][8:5]));
        end

        // R8 strobe cycle: finish at edge 17*P, seen at sample 17*P+1
        send_frame(1'b0, 1'b0, 20, 4, 20, -1, 0);
        chk(sv_idx == 17*35+1, "R8 slow latency", sv_idx, 17*35+1);
        send_frame(1'b1, 1'b0, 7, 9, 7, -1, 0);
        chk(sv_idx == 17*10+1, "R8 fast latency", sv_idx, 17*10+1);

        // R5 mode flip after reference edge is ignored
        send_frame(1'b0, 1'b1, 20, 6, 20, -1, 0);
        chk(n_sv == 1 && cap_data == 4'd6, "R5 slow flip", int'(cap_data), 6);
        send_frame(1'b1, 1'b1, 7, 11, 7, -1, 0);
        chk(n_sv == 1 && cap_data == 4'd11, "R5 fast flip", int'(cap_data), 11);

        // R6 reference gap too wide
        send_frame(1'b0, 1'b0, 32, 5, 20, -1, 0);
        chk(n_se == 1 && n_sv == 0, "R6 wide reference", n_sv, 0);

        // R7 no gap, two gaps
        send_frame(1'b0, 1'b0, 20, -1, 0, -1, 0);
        chk(n_se == 1 && n_sv == 0, "R7 no gap", n_sv, 0);
        send_frame(1'b1, 1'b0, 7, 4, 7, 11, 7);
        chk(n_se == 1 && n_sv == 0, "R7 two gaps", n_sv, 0);

        // R9 R10 word with good parity: id A5, type 5, parity 0 -> third nibble A
        good_sym(1'b0, 10, "R9 w1 s1");
        good_sym(1'b0, 5,  "R9 w1 s2");
        good_sym(1'b0, 10, "R9 w1 s3");
        chk(n_mc == 1 && n_pe == 0, "R10 w1 verdict", n_mc, 1);
        chk(cap_id == 8'hA5 && cap_type == 3'd5, "R9 w1 fields", int'(cap_id), 'hA5);
        chk(word_idx == sv_idx, "R10 w1 same cycle", word_idx, sv_idx);

        // R10 wrong parity: third nibble B
        good_sym(1'b0, 10, "R10 w2 s1");
        good_sym(1'b0, 5,  "R10 w2 s2");
        good_sym(1'b0, 11, "R10 w2 s3");
        chk(n_pe == 1 && n_mc == 0, "R10 w2 parity error", n_pe, 1);
        chk(word_idx == sv_idx, "R10 w2 same cycle", word_idx, sv_idx);

        // R9 fast word: id 3C, type 3 -> third nibble 6
        good_sym(1'b1, 3,  "R9 w3 s1");
        good_sym(1'b1, 12, "R9 w3 s2");
        good_sym(1'b1, 6,  "R9 w3 s3");
        chk(n_mc == 1 && cap_id == 8'h3C && cap_type == 3'd3, "R9 w3 fields", int'(cap_id), 'h3C);

        // R11 error mid-word restarts collection
        good_sym(1'b0, 10, "R11 s1");
        send_frame(1'b0, 1'b0, 20, -1, 0, -1, 0);
        chk(n_se == 1 && n_mc == 0 && n_pe == 0, "R11 error frame", n_se, 1);
        good_sym(1'b0, 10, "R11 s2");
        good_sym(1'b0, 5,  "R11 s3");
        chk(n_mc == 0 && n_pe == 0, "R11 no early word", n_mc, 0);
        good_sym(1'b0, 10, "R11 s4");
        chk(n_mc == 1 && cap_id == 8'hA5, "R11 fresh word", int'(cap_id), 'hA5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule